// File: doc/BRIEF.md
# Dual-Lane 32-bit R-Type ALU

A purely combinational arithmetic and logic unit for register-to-register instructions. A 6-bit function code picks the operation. The unit takes two source words (`rs_val`, `rt_val`), the current value of the destination register (`rd_val`) and a 5-bit shift amount. It returns a single 32-bit word to be written back. Scalar operations treat each word as one 32-bit quantity.

The lane forms split every word into two independent 16-bit halves. Each half is computed on its own, and both results leave in the same write. A packing operation assembles a word from chosen halves of the two sources. Half-word moves use `rd_val` so that the untouched half of the destination survives the single write.

Function codes outside the defined set give a zero result and raise `illegal`. The unit has no clock and no state. It sits between operand read and write-back in the execute stage.

Top module: `dual_lane_alu`

## Requirements
- R1: Codes 000000 and 000001 give `rs_val + rt_val` modulo 2^32. Codes 001000 and 001001 give `rs_val - rt_val` modulo 2^32.
- R2: Codes 010000, 010001 and 010010 give the bitwise AND, OR and XOR of `rs_val` and `rt_val`.
- R3: Code 100000 gives 1 when `rs_val` is less than `rt_val` as signed values, and 0 otherwise.
- R4: Code 011000 shifts `rs_val` right by `shamt` and fills with zeros. Code 011001 does the same shift but fills with copies of bit 31.
- R5: Codes 101000 and 110000 give the signed minimum and signed maximum of the two sources. Code 111000 gives the absolute value of `rs_val`; for 0x80000000 it returns 0x80000000 unchanged.
- R6: Codes 101001, 110001 and 111001 apply signed minimum, signed maximum and absolute value separately to bits [31:16] and to bits [15:0]. An absolute value of 0x8000 in a half stays 0x8000.
- R7: Codes 000010 and 000011 add per 16-bit half. Codes 001010 and 001011 subtract per 16-bit half. Each half wraps modulo 2^16, and no carry or borrow passes between bit 15 and bit 16.
- R8: Code 000100 gives `rs_val`. Code 000101 gives {`rd_val`[31:16], `rs_val`[15:0]}. Code 000110 gives {`rs_val`[31:16], `rd_val`[15:0]}.
- R9: Codes 0111ab build a packed word. The upper half is `rs_val`[31:16] when a=1 and `rs_val`[15:0] when a=0. The lower half is `rt_val`[31:16] when b=1 and `rt_val`[15:0] when b=0.
- R10: Any code not named in R1 to R9 drives `result` to zero and `illegal` to 1. `illegal` is 0 for every named code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| funct | input | 6 | Operation select code |
| shamt | input | 5 | Right-shift distance |
| rs_val | input | 32 | First source operand |
| rt_val | input | 32 | Second source operand |
| rd_val | input | 32 | Current destination value, used by half moves |
| result | output | 32 | Value to write back |
| illegal | output | 1 | Function code is undefined |

## Verification
All results are combinational, so every output is due in the same cycle as its stimulus, with no clock edge in between. The bench changes the inputs just after a falling clock edge. It samples 2 ns later, while the inputs are still stable and before the next rising edge. Each output is therefore compared against the inputs that produced it.

The stimulus covers all 64 function codes against a set of corner operands and pseudo-random operands. It also sweeps all 32 shift distances for both shift codes.

// File: rtl/dual_lane_alu.sv
module dual_lane_alu #(
  parameter int LANE = 16
) (
  input  logic [5:0]                  funct,
  input  logic [$clog2(2*LANE)-1:0]   shamt,
  input  logic [2*LANE-1:0]           rs_val,
  input  logic [2*LANE-1:0]           rt_val,
  input  logic [2*LANE-1:0]           rd_val,
  output logic [2*LANE-1:0]           result,
  output logic                        illegal
);
  localparam int W = 2 * LANE;

  logic [W-1:0] l_add, l_sub, l_min, l_max, l_abs;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [LANE-1:0] a, b;
    assign a = rs_val[g*LANE +: LANE];
    assign b = rt_val[g*LANE +: LANE];
    assign l_add[g*LANE +: LANE] = a + b;
    assign l_sub[g*LANE +: LANE] = a - b;
    assign l_min[g*LANE +: LANE] = ($signed(a) < $signed(b)) ? a : b;
    assign l_max[g*LANE +: LANE] = ($signed(a) > $signed(b)) ? a : b;
    assign l_abs[g*LANE +: LANE] = a[LANE-1] ? LANE'(LANE'(0) - a) : a;
  end

  logic          s_lt;
  logic [W-1:0]  s_abs;
  logic [LANE-1:0] rs_pick, rt_pick;

  assign s_lt    = $signed(rs_val) < $signed(rt_val);
  assign s_abs   = rs_val[W-1] ? W'(W'(0) - rs_val) : rs_val;
  assign rs_pick = funct[1] ? rs_val[W-1:LANE] : rs_val[LANE-1:0];
  assign rt_pick = funct[0] ? rt_val[W-1:LANE] : rt_val[LANE-1:0];

  always_comb begin
    illegal = 1'b0;
    result  = '0;
    casez (funct)
      6'b00000?: result = rs_val + rt_val;
      6'b00100?: result = rs_val - rt_val;
      6'b00001?: result = l_add;
      6'b00101?: result = l_sub;
      6'b010000: result = rs_val & rt_val;
      6'b010001: result = rs_val | rt_val;
      6'b010010: result = rs_val ^ rt_val;
      6'b100000: result = W'(s_lt);
      6'b011000: result = rs_val >> shamt;
      6'b011001: result = W'($signed(rs_val) >>> shamt);
      6'b101000: result = s_lt ? rs_val : rt_val;
      6'b110000: result = s_lt ? rt_val : rs_val;
      6'b111000: result = s_abs;
      6'b101001: result = l_min;
      6'b110001: result = l_max;
      6'b111001: result = l_abs;
      6'b000100: result = rs_val;
      6'b000101: result = {rd_val[W-1:LANE], rs_val[LANE-1:0]};
      6'b000110: result = {rs_val[W-1:LANE], rd_val[LANE-1:0]};
      6'b0111??: result = {rs_pick, rt_pick};
      default:   illegal = 1'b1;
    endcase
  end
endmodule

module dual_lane_alu_chk #(
  parameter int LANE = 16
) (
  input logic [5:0]         funct,
  input logic [2*LANE-1:0]  rs_val,
  input logic [2*LANE-1:0]  rt_val,
  input logic [2*LANE-1:0]  rd_val,
  input logic [2*LANE-1:0]  result,
  input logic               illegal
);
  localparam int W = 2 * LANE;

  always_comb begin
    // R10
    if (illegal) begin
      illegal_zero_chk: assert (result == '0);
    end
    // R3
    if (funct == 6'b100000) begin
      slt_bit_chk: assert (result[W-1:1] == '0);
    end
    // R5
    if (funct == 6'b111000) begin
      abs_sign_chk: assert (!result[W-1] || (result == rs_val));
    end
    // R7
    if (funct == 6'b000010) begin
      lane_carry_chk: assert (result[LANE-1:0] == LANE'(rs_val[LANE-1:0] + rt_val[LANE-1:0]));
    end
    // R8
    if (funct == 6'b000101) begin
      movl_keep_chk: assert (result[W-1:LANE] == rd_val[W-1:LANE]);
    end
    // R9
    if (funct[5:2] == 4'b0111) begin
      pack_hi_chk: assert (result[W-1:LANE] == rs_val[W-1:LANE] || result[W-1:LANE] == rs_val[LANE-1:0]);
    end
  end
endmodule

bind dual_lane_alu dual_lane_alu_chk #(.LANE(LANE)) chk_i (
  .funct(funct), .rs_val(rs_val), .rt_val(rt_val), .rd_val(rd_val),
  .result(result), .illegal(illegal)
);

// File: tb/dual_lane_alu_tb.sv
module dual_lane_alu_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [5:0]  funct = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] rs_val = '0, rt_val = '0, rd_val = '0;
  logic [31:0] result;
  logic        illegal;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  dual_lane_alu dut_i (
    .funct(funct), .shamt(shamt), .rs_val(rs_val), .rt_val(rt_val),
    .rd_val(rd_val), .result(result), .illegal(illegal)
  );

  function automatic logic [15:0] h_min(logic [15:0] a, logic [15:0] b);
    int x = $signed(a), y = $signed(b);
    return (x < y) ? a : b;
  endfunction
  function automatic logic [15:0] h_max(logic [15:0] a, logic [15:0] b);
    int x = $signed(a), y = $signed(b);
    return (x > y) ? a : b;
  endfunction
  function automatic logic [15:0] h_abs(logic [15:0] a);
    int x = $signed(a);
    if (x < 0) x = -x;
    return x[15:0];
  endfunction

  function automatic string req_of(logic [5:0] f);
    case (f)
      6'h00, 6'h01, 6'h08, 6'h09: return "R1";
      6'h10, 6'h11, 6'h12: return "R2";
      6'h20: return "R3";
      6'h18, 6'h19: return "R4";
      6'h28, 6'h30, 6'h38: return "R5";
      6'h29, 6'h31, 6'h39: return "R6";
      6'h02, 6'h03, 6'h0A, 6'h0B: return "R7";
      6'h04, 6'h05, 6'h06: return "R8";
      6'h1C, 6'h1D, 6'h1E, 6'h1F: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic model(input logic [5:0] f, input logic [4:0] sh,
                       input logic [31:0] a, b, d,
                       output logic [31:0] r, output logic ill);
    longint sa = $signed(a), sb = $signed(b);
    ill = 0;
    r = 0;
    case (f)
      6'h00, 6'h01: r = 32'(a + b);
      6'h08, 6'h09: r = 32'(a - b);
      6'h02, 6'h03: r = {16'(a[31:16] + b[31:16]), 16'(a[15:0] + b[15:0])};
      6'h0A, 6'h0B: r = {16'(a[31:16] - b[31:16]), 16'(a[15:0] - b[15:0])};
      6'h10: r = a & b;
      6'h11: r = a | b;
      6'h12: r = a ^ b;
      6'h20: r = (sa < sb) ? 32'd1 : 32'd0;
      6'h18: r = 32'(longint'({32'd0, a}) / (64'd1 << sh));
      6'h19: r = 32'(sa >>> sh);
      6'h28: r = (sa < sb) ? a : b;
      6'h30: r = (sa > sb) ? a : b;
      6'h38: r = (sa < 0) ? 32'(-sa) : a;
      6'h29: r = {h_min(a[31:16], b[31:16]), h_min(a[15:0], b[15:0])};
      6'h31: r = {h_max(a[31:16], b[31:16]), h_max(a[15:0], b[15:0])};
      6'h39: r = {h_abs(a[31:16]), h_abs(a[15:0])};
      6'h04: r = a;
      6'h05: r = {d[31:16], a[15:0]};
      6'h06: r = {a[31:16], d[15:0]};
      6'h1C: r = {a[15:0], b[15:0]};
      6'h1D: r = {a[15:0], b[31:16]};
      6'h1E: r = {a[31:16], b[15:0]};
      6'h1F: r = {a[31:16], b[31:16]};
      default: ill = 1;
    endcase
  endtask

  task automatic apply(input logic [5:0] f, input logic [4:0] sh,
                       input logic [31:0] a, b, d);
    logic [31:0] er;
    logic ei;
    @(negedge clk);
    funct = f; shamt = sh; rs_val = a; rt_val = b; rd_val = d;
    #2;
    model(f, sh, a, b, d, er, ei);
    total++;
    if (result !== er || illegal !== ei) begin
      bad++;
      $display("FAIL %s funct=%b shamt=%0d rs=%h rt=%h rd=%h actual=%h/%b expected=%h/%b",
               req_of(f), f, sh, a, b, d, result, illegal, er, ei);
    end
  endtask

  logic [31:0] pats [12] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000,
                             32'h7FFF_FFFF, 32'h0000_8000, 32'h7FFF_8000, 32'h8000_7FFF,
                             32'h0000_FFFF, 32'hFFFF_0001, 32'h1234_ABCD, 32'hFEDC_0123};

  initial begin
    logic [31:0] lfsr = 32'hACE1_1234;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // Reset / idle state: all-zero inputs give zero result, no illegal (R1, R10)
    apply(6'h00, 5'd0, 32'h0, 32'h0, 32'h0);
    // Full sweep of codes against corner operand pairs (R1..R10)
    for (int f = 0; f < 64; f++)
      for (int i = 0; i < 12; i++)
        apply(6'(f), 5'(i * 3), pats[i], pats[(i * 5 + 3) % 12], pats[(i + 7) % 12]);
    // Shift distance sweep (R4)
    for (int s = 0; s < 32; s++) begin
      apply(6'h18, 5'(s), 32'h8765_4321, 32'h0, 32'h0);
      apply(6'h19, 5'(s), 32'h8765_4321, 32'h0, 32'h0);
      apply(6'h19, 5'(s), 32'h7654_3210, 32'h0, 32'h0);
    end
    // Most negative abs values (R5, R6)
    apply(6'h38, 5'd0, 32'h8000_0000, 32'h0, 32'h0);
    apply(6'h39, 5'd0, 32'h8000_8000, 32'h0, 32'h0);
    // Lane carry isolation (R7)
    apply(6'h02, 5'd0, 32'h0000_FFFF, 32'h0000_0001, 32'h0);
    apply(6'h0A, 5'd0, 32'h0001_0000, 32'h0000_0001, 32'h0);
    // Pseudo-random operands over all codes
    for (int k = 0; k < 2000; k++) begin
      logic [31:0] a, b, d;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; a = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; b = lfsr ^ 32'h5A5A_0F0F;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; d = {lfsr[15:0], lfsr[31:16]};
      apply(6'(k % 64), 5'(a[4:0]), a, b, d);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected<=150000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule